// File: doc/BRIEF.md
# 66-bit Block Boundary Lock

This block recovers the block boundary of one lane carrying 64B/66B-coded, scrambled data. Every clock on which the input is qualified it receives one 66-bit word of the serial stream, keeps the previous word, and forms a 132-bit window from the two. One candidate bit offset into that window is tested at a time by looking at the two framing bits the candidate places at the start of a block. While the block is hunting, a bad framing pair moves the candidate by one bit and the search continues. Enough consecutive good pairs at one offset declare lock.

Once locked, the block hands out each aligned 66-bit block with a valid strobe. It watches for bad framing pairs in consecutive windows of blocks. A single bad pair or a small cluster is tolerated. A dense cluster, which is the sign of a false lock on scrambled payload or of a real loss of alignment, drops the lock. The block then moves to the next offset and starts hunting again without outside help. Right after every offset change, a short settle period lets the new candidate take effect before any framing pair is judged.

Top module: `sync_block_align`

## Requirements
- R1: A framing pair is good when outBlock[1:0] (bit 0 earliest in time) is 2'b01 or 2'b10. The values 2'b00 and 2'b11 are bad.
- R2: inWord bit 0 is the earliest bit of the word. The candidate block starts alignOffset bits into the previous qualified word and runs across 66 consecutive stream bits. The first qualified word after reset only fills the window and is not judged.
- R3: While hunting, LOCK_CNT consecutive good pairs at one offset set blockLock. It rises on the edge that samples the word carrying the last of them.
- R4: Only one offset is tested at a time. A bad pair while hunting advances alignOffset by one, wrapping from 65 to 0, and restarts the good-pair count.
- R5: After any change of offset, the framing pairs of the next SETTLE qualified words are ignored.
- R6: While locked, blocks are counted in consecutive windows of WIN_LEN blocks, the first beginning with the block after the one that set lock. Fewer than BAD_LIMIT bad pairs in a window leave blockLock high.
- R7: BAD_LIMIT bad pairs within one window clear blockLock on the edge that samples the last of them, advance alignOffset by one, and restart the hunt on their own.
- R8: outValid is high only together with blockLock. It pulses once for each qualified word sampled while the lock holds after that edge, with outBlock holding that word's aligned block.
- R9: A cycle with inValid low changes neither blockLock nor alignOffset and leaves outValid low.
- R10: A synchronous active-high rst clears blockLock, outValid, all counters and alignOffset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies inWord in this cycle |
| inWord | input | 66 | Next 66 stream bits, bit 0 earliest |
| outValid | output | 1 | Aligned block on outBlock is valid |
| outBlock | output | 66 | Aligned block, framing pair in bits 1:0 |
| blockLock | output | 1 | Block boundary is locked |
| alignOffset | output | 7 | Current candidate bit offset, 0 to 65 |

## Verification
The bench builds the block with LOCK_CNT=4, BAD_LIMIT=3, WIN_LEN=8 and SETTLE=2. These values make the exact lock cycle, the settle delay and the window edges short enough to predict word by word. The stream is made so that no wrong offset sees two good pairs in a row. With that, the bench sweeps all 66 boundary phases, with and without idle gaps, and every phase is expected to lock at an offset equal to the phase. It also places clusters of bad pairs that either straddle a window edge or fall inside one window. This checks tolerance and unlock, followed by a full search that wraps through offset 65 back to 0.

// File: rtl/sync_block_align_pkg.sv
package sync_block_align_pkg;

  // Strobes issued by the control path to the datapath each cycle.
  typedef struct packed {
    logic take;   // a qualified word is present: shift it into the window
    logic slip;   // move the candidate offset forward by one bit
    logic emit;   // publish the aligned block of this word
  } alignStrobe_t;

  typedef enum logic [0:0] {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lockState_t;

endpackage

// File: rtl/sba_datapath.sv
module sba_datapath
  import sync_block_align_pkg::*;
#(
  parameter int BLOCK_W = 66,
  localparam int OFS_W = $clog2(BLOCK_W),
  localparam int WIN_W = 2 * BLOCK_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BLOCK_W-1:0] inWord,
  input  alignStrobe_t       strobe,
  output logic               headerOk,
  output logic [OFS_W-1:0]   alignOffset,
  output logic               outValid,
  output logic [BLOCK_W-1:0] outBlock
);

  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(BLOCK_W - 1);

  logic [BLOCK_W-1:0] prevWord;
  logic [WIN_W-1:0]   window;
  logic [BLOCK_W-1:0] candBlock;
  logic [OFS_W-1:0]   offsetNext;

  // Older word sits in the low half so that bit index follows arrival time.
  assign window = {inWord, prevWord};

  // One selector per block bit: bit b of the candidate comes from window
  // position alignOffset + b.
  for (genvar b = 0; b < BLOCK_W; b++) begin : g_sel
    logic [OFS_W:0] pos;
    assign pos = {1'b0, alignOffset} + (OFS_W + 1)'(b);
    assign candBlock[b] = window[pos];
  end

  // Framing pair is good when its two bits differ.
  assign headerOk = candBlock[0] ^ candBlock[1];

  always_comb begin
    offsetNext = alignOffset;
    if (strobe.slip) begin
      offsetNext = (alignOffset == LAST_OFS) ? '0 : alignOffset + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevWord    <= '0;
      alignOffset <= '0;
      outValid    <= 1'b0;
      outBlock    <= '0;
    end else begin
      alignOffset <= offsetNext;
      outValid    <= strobe.emit;
      if (strobe.take) begin
        prevWord <= inWord;
      end
      if (strobe.emit) begin
        outBlock <= candBlock;
      end
    end
  end

endmodule

// File: rtl/sba_control.sv
module sba_control
  import sync_block_align_pkg::*;
#(
  parameter int LOCK_CNT  = 64,
  parameter int BAD_LIMIT = 16,
  parameter int WIN_LEN   = 64,
  parameter int SETTLE    = 2,
  localparam int GOOD_W = (LOCK_CNT  < 2) ? 1 : $clog2(LOCK_CNT),
  localparam int BAD_W  = (BAD_LIMIT < 2) ? 1 : $clog2(BAD_LIMIT),
  localparam int WCNT_W = (WIN_LEN   < 2) ? 1 : $clog2(WIN_LEN),
  localparam int SET_W  = (SETTLE    < 1) ? 1 : $clog2(SETTLE + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         headerOk,
  output alignStrobe_t strobe,
  output logic         blockLock
);

  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_CNT - 1);
  localparam logic [BAD_W-1:0]  BAD_LAST  = BAD_W'(BAD_LIMIT - 1);
  localparam logic [WCNT_W-1:0] WIN_LAST  = WCNT_W'(WIN_LEN - 1);

  lockState_t        state, stateNext;
  logic              primed, primedNext;
  logic [GOOD_W-1:0] goodCnt, goodNext;
  logic [BAD_W-1:0]  badCnt, badNext;
  logic [WCNT_W-1:0] winCnt, winNext;
  logic [SET_W-1:0]  settleCnt, settleNext;
  logic              settling;
  logic              judge;
  logic              slipReq;

  // Settle counter variant: with SETTLE of zero no pair is ever skipped.
  if (SETTLE > 0) begin : g_settle
    assign settling = (settleCnt != '0);
  end else begin : g_nosettle
    assign settling = 1'b0;
  end

  assign judge = inValid && primed && !settling;

  always_comb begin
    stateNext  = state;
    primedNext = primed;
    goodNext   = goodCnt;
    badNext    = badCnt;
    winNext    = winCnt;
    settleNext = settleCnt;
    slipReq    = 1'b0;

    if (inValid) begin
      primedNext = 1'b1;
      if (primed && settling) begin
        settleNext = settleCnt - 1'b1;
      end
    end

    if (judge) begin
      unique case (state)
        ST_HUNT: begin
          if (headerOk) begin
            if (goodCnt == GOOD_LAST) begin
              stateNext = ST_LOCK;
              goodNext  = '0;
              badNext   = '0;
              winNext   = '0;
            end else begin
              goodNext = goodCnt + 1'b1;
            end
          end else begin
            slipReq    = 1'b1;
            goodNext   = '0;
            settleNext = SET_W'(SETTLE);
          end
        end
        ST_LOCK: begin
          if (!headerOk && badCnt == BAD_LAST) begin
            stateNext  = ST_HUNT;
            slipReq    = 1'b1;
            goodNext   = '0;
            badNext    = '0;
            winNext    = '0;
            settleNext = SET_W'(SETTLE);
          end else if (winCnt == WIN_LAST) begin
            winNext = '0;
            badNext = '0;
          end else begin
            winNext = winCnt + 1'b1;
            if (!headerOk) begin
              badNext = badCnt + 1'b1;
            end
          end
        end
        default: stateNext = ST_HUNT;
      endcase
    end
  end

  always_comb begin
    strobe.take = inValid;
    strobe.slip = slipReq;
    strobe.emit = inValid && (stateNext == ST_LOCK);
  end

  assign blockLock = (state == ST_LOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HUNT;
      primed    <= 1'b0;
      goodCnt   <= '0;
      badCnt    <= '0;
      winCnt    <= '0;
      settleCnt <= '0;
    end else begin
      state     <= stateNext;
      primed    <= primedNext;
      goodCnt   <= goodNext;
      badCnt    <= badNext;
      winCnt    <= winNext;
      settleCnt <= settleNext;
    end
  end

endmodule

// File: rtl/sync_block_align.sv
module sync_block_align
  import sync_block_align_pkg::*;
#(
  parameter int BLOCK_W   = 66,
  parameter int LOCK_CNT  = 64,
  parameter int BAD_LIMIT = 16,
  parameter int WIN_LEN   = 64,
  parameter int SETTLE    = 2,
  localparam int OFS_W = $clog2(BLOCK_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [BLOCK_W-1:0] inWord,
  output logic               outValid,
  output logic [BLOCK_W-1:0] outBlock,
  output logic               blockLock,
  output logic [OFS_W-1:0]   alignOffset
);

  alignStrobe_t strobe;
  logic         headerOk;

  sba_control #(
    .LOCK_CNT (LOCK_CNT),
    .BAD_LIMIT(BAD_LIMIT),
    .WIN_LEN  (WIN_LEN),
    .SETTLE   (SETTLE)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .headerOk (headerOk),
    .strobe   (strobe),
    .blockLock(blockLock)
  );

  sba_datapath #(
    .BLOCK_W(BLOCK_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .inWord     (inWord),
    .strobe     (strobe),
    .headerOk   (headerOk),
    .alignOffset(alignOffset),
    .outValid   (outValid),
    .outBlock   (outBlock)
  );

endmodule

// File: rtl/sync_block_align_chk.sv
module sync_block_align_chk #(
  parameter int BLOCK_W = 66,
  localparam int OFS_W = $clog2(BLOCK_W)
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             outValid,
  input logic             blockLock,
  input logic [OFS_W-1:0] alignOffset
);

  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(BLOCK_W - 1);

  // R8
  emit_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> blockLock);

  // R4
  slip_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && alignOffset != $past(alignOffset)) |->
      (alignOffset == (($past(alignOffset) == LAST_OFS) ? '0 : $past(alignOffset) + 1'b1)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(blockLock) && $stable(alignOffset) && !outValid));

  // R7
  unlock_slips_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(blockLock)) |-> (alignOffset != $past(alignOffset)));

  // R3
  lock_on_word_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(blockLock)) |-> ($past(inValid) && outValid));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!blockLock && alignOffset == '0 && !outValid));

endmodule

bind sync_block_align sync_block_align_chk #(.BLOCK_W(BLOCK_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .outValid   (outValid),
  .blockLock  (blockLock),
  .alignOffset(alignOffset)
);

// File: tb/sync_block_align_test.sv
module sync_block_align_test;

  localparam int BW = 66;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [BW-1:0] inWord = '0;
  logic          outValid;
  logic [BW-1:0] outBlock;
  logic          blockLock;
  logic [6:0]    alignOffset;

  int total = 0;
  int bad = 0;
  int ph = 0;
  int errLo = 1000000;
  int errHi = -1;
  int errList[6];
  int wordIdx = 0;
  int cycles = 0;
  bit done = 1'b0;

  sync_block_align #(
    .BLOCK_W(BW), .LOCK_CNT(4), .BAD_LIMIT(3), .WIN_LEN(8), .SETTLE(2)
  ) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .outBlock(outBlock), .blockLock(blockLock),
    .alignOffset(alignOffset)
  );

  always #5 clk = ~clk;

  function automatic bit isErr(int k);
    for (int i = 0; i < 6; i++) if (errList[i] == k) return 1'b1;
    return 1'b0;
  endfunction

  // Stream: fill of ones before phase ph, then blocks with pair (1,0).
  // Payload bit 0 alternates by block, so no wrong offset sees two good
  // pairs in a row. Errors: pair 11 for blocks below 16, pair 00 above.
  function automatic logic bitAt(int p);
    int q, k, j;
    if (p < ph) return 1'b1;
    q = p - ph;
    k = q / BW;
    j = q % BW;
    if (j == 0) return isErr(k) ? (k < 16) : 1'b1;
    if (j == 1) return isErr(k) ? (k < 16) : 1'b0;
    if (j == 2) return (k % 2 == 1) ? 1'b0 : 1'b1;
    return 1'b1;
  endfunction

  function automatic logic [BW-1:0] wordAt(int n);
    logic [BW-1:0] w;
    for (int i = 0; i < BW; i++) w[i] = bitAt(BW * n + i);
    return w;
  endfunction

  function automatic logic [BW-1:0] blockAt(int k);
    logic [BW-1:0] w;
    for (int i = 0; i < BW; i++) w[i] = bitAt(ph + BW * k + i);
    return w;
  endfunction

  task automatic check(bit ok, string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearErrs();
    for (int i = 0; i < 6; i++) errList[i] = -100;
  endtask

  task automatic doReset();
    rst = 1'b1;
    inValid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    wordIdx = 0;
  endtask

  task automatic sendWord();
    inValid = 1'b1;
    inWord = wordAt(wordIdx);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    wordIdx++;
  endtask

  task automatic idle();
    inValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit seen65;
    int lim;
    clearErrs();

    // R10: reset state
    ph = 0;
    doReset();
    check(!blockLock && !outValid && alignOffset == 0, "R10 reset clear",
          {blockLock, outValid, alignOffset}, '0);

    // R3/R2: phase 0 locks after prime word plus four good pairs
    sendWord();
    check(!blockLock && !outValid, "R2 prime word not judged", blockLock, 0);
    for (int i = 1; i < 4; i++) begin
      sendWord();
      check(!blockLock, "R3 no early lock", blockLock, 0);
      check(!outValid, "R8 no output while hunting", outValid, 0);
    end
    sendWord();
    check(blockLock, "R3 lock on fourth good pair", blockLock, 1);
    check(outValid, "R8 strobe with lock word", outValid, 1);
    check(outBlock == blockAt(3), "R8 aligned block", outBlock, blockAt(3));
    check(outBlock[1:0] == 2'b01, "R1 framing pair of output", outBlock[1:0], 2'b01);
    check(alignOffset == 0, "R4 no slip at phase 0", alignOffset, 0);

    // R9: idle cycles change nothing
    idle();
    check(!outValid && blockLock && alignOffset == 0, "R9 idle hold",
          {outValid, blockLock, alignOffset}, {1'b0, 1'b1, 7'd0});
    idle();

    // R6: 10,11 end one window, 12 starts the next (pair 11): lock holds.
    // R7: 20,22,24 in one window (pair 00): lock drops on word 25.
    errList[0] = 10; errList[1] = 11; errList[2] = 12;
    errList[3] = 20; errList[4] = 22; errList[5] = 24;
    for (int i = 5; i < 25; i++) begin
      sendWord();
      check(blockLock, "R6 lock tolerates sparse bad pairs", blockLock, 1);
      check(outValid && outBlock == blockAt(i - 1), "R8 block per word",
            outBlock, blockAt(i - 1));
    end
    sendWord();
    check(!blockLock, "R7 unlock on third bad pair", blockLock, 0);
    check(!outValid, "R8 no strobe on unlock word", outValid, 0);
    check(alignOffset == 1, "R7 slip on unlock", alignOffset, 1);

    // R7/R4: automatic search wraps through 65 back to 0
    seen65 = 1'b0;
    lim = 0;
    while (!blockLock && lim < 900) begin
      sendWord();
      if (alignOffset == 65) seen65 = 1'b1;
      if (!blockLock) check(!outValid, "R8 quiet while searching", outValid, 0);
      lim++;
    end
    check(blockLock, "R7 relock after search", blockLock, 1);
    check(alignOffset == 0, "R4 offset wraps to 0", alignOffset, 0);
    check(seen65, "R4 search reaches offset 65", seen65, 1);

    // R10: reset while locked
    doReset();
    check(!blockLock && !outValid && alignOffset == 0, "R10 reset while locked",
          {blockLock, outValid, alignOffset}, '0);

    // R5: phase 1. Word 1 slips, words 2,3 settle, words 4..7 lock.
    clearErrs();
    ph = 1;
    sendWord();
    sendWord();
    check(alignOffset == 1 && !blockLock, "R4 slip after bad pair",
          alignOffset, 1);
    for (int i = 2; i < 7; i++) begin
      sendWord();
      check(!blockLock, "R5 settle words ignored", blockLock, 0);
    end
    sendWord();
    check(blockLock, "R5 lock after settle plus four", blockLock, 1);
    check(outBlock == blockAt(6), "R2 block at offset 1", outBlock, blockAt(6));

    // Sweep all phases; odd phases get idle gaps (R9)
    for (int p = 0; p < BW; p++) begin
      ph = p;
      doReset();
      lim = 0;
      while (!blockLock && lim < 900) begin
        if ((p % 2 == 1) && (lim % 3 == 2)) idle();
        sendWord();
        lim++;
      end
      check(blockLock, "R3 sweep lock", blockLock, 1);
      check(alignOffset == 7'(p), "R4 sweep offset equals phase", alignOffset, 7'(p));
      check(outBlock == blockAt(wordIdx - 2), "R2 sweep lock block",
            outBlock, blockAt(wordIdx - 2));
      for (int i = 0; i < 2; i++) begin
        sendWord();
        check(outValid && outBlock == blockAt(wordIdx - 2), "R8 sweep block",
              outBlock, blockAt(wordIdx - 2));
        check(outBlock[0] != outBlock[1], "R1 sweep pair good", outBlock[1:0], 2'b01);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule